// File: doc/BRIEF.md
# Prioritised CPU Interrupt Controller

This block sits beside a processor core and decides which of sixteen interrupt lines the core services next. Every line has a flag that records an event. A maskable line can raise a request only when two things hold: its own enable bit is set, and the global enable bit is set. Line 0 is the reset line. It cannot be masked and it always wins. Lines 1 to 3 are reserved: they never latch and never request. Among the maskable lines 4 to 15, the lowest index wins.

The core sees a request flag and a vector number. When it accepts the request it pulses the acknowledge input and presents its current program counter. In that same edge the controller does four things: it clears the winning flag, clears global enable, remembers the old global-enable value and stores the program counter as the return address. A return-from-interrupt pulse later puts global enable back to the value it had before the acknowledge. Software reaches the flags, the enables and the global bit through a small register port. The read data is combinational on the select lines.

Top module: `cpu_irq_ctrl`

## Requirements
- R1: A high event input on line 0 or on lines 4..15 sets that line's flag at the next clock edge. Events on lines 1..3 never set a flag, so flag bits 1..3 always read 0.
- R2: A maskable line requests only when its flag is set, its enable bit is set and global enable is 1.
- R3: A set line-0 flag raises a request with vector 0 whatever the enable bits and global enable are.
- R4: When several lines qualify, line 0 wins first. After that, the qualifying maskable line with the lowest index wins.
- R5: An acknowledge while a request is present clears only the winning flag. All other flags are unchanged.
- R6: An accepted acknowledge clears global enable at that edge and captures the program counter input on the return-address output.
- R7: A return-from-interrupt pulse (with no accepted acknowledge in the same cycle) sets global enable to the value it held just before the most recent accepted acknowledge.
- R8: An event on a line in the same cycle as that line's flag is cleared (by acknowledge or by software) leaves the flag set.
- R9: Register port, selected by `reg_sel`:
  - 0: a write clears the flags whose data bits are 1; reads return the flags.
  - 1: a write sets the flags whose data bits are 1 (lines 1..3 ignored); reads return the flags.
  - 2: a write loads the enable bits (bits 0..3 are ignored and read 0); reads return the enable bits.
  - 3: a write loads global enable from data bit 0; reads return global enable in bit 0 and the saved value in bit 1.
  - If an accepted acknowledge or a return-from-interrupt occurs in the same cycle as a write to select 3, the acknowledge or the return wins.
- R10: An acknowledge while no request is present changes no flag, no enable bit and no return address.
- R11: After reset, all flags and enables are 0, global enable and its saved copy are 0, the return address is 0 and there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 16 | Event inputs, one per line, sampled each edge |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the current select |
| irq_req | output | 1 | A line is ready to be taken |
| irq_vec | output | 4 | Index of the winning line |
| irq_ack | input | 1 | Core accepts the presented interrupt |
| pc_in | input | 32 | Program counter to save on acknowledge |
| rti | input | 1 | Return from interrupt |
| ret_addr | output | 32 | Saved return address |

## Verification
A wrong flag, enable or global bit shows at the ports in two ways. The register read data for that select is wrong in the cycle right after the faulty edge. The request and vector outputs are also wrong in that cycle, because both depend combinationally on the stored state. A wrong saved global-enable copy stays hidden until a return-from-interrupt or a select-3 read, and then it is visible in the next cycle. Since the bench compares every output against its own model on every cycle, a fault is reported within one cycle of the point where it can first be observed.

// File: rtl/cpu_irq_ctrl.sv
module cpu_irq_ctrl #(
  parameter int NUM_LINES      = 16,
  parameter int FIRST_MASKABLE = 4,
  parameter int PC_W           = 32,
  localparam int VEC_W         = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src_evt,
  input  logic                 reg_we,
  input  logic [1:0]           reg_sel,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic                 irq_req,
  output logic [VEC_W-1:0]     irq_vec,
  input  logic                 irq_ack,
  input  logic [PC_W-1:0]      pc_in,
  input  logic                 rti,
  output logic [PC_W-1:0]      ret_addr
);

  localparam logic [NUM_LINES-1:0] MASKABLE  = {NUM_LINES{1'b1}} << FIRST_MASKABLE;
  localparam logic [NUM_LINES-1:0] LATCHABLE = MASKABLE | NUM_LINES'(1);

  logic [NUM_LINES-1:0] flag_q, ier_q, cand, set_v, clr_v;
  logic                 gie_q, sav_q, take;
  logic [VEC_W-1:0]     win_idx;
  logic                 win_vld;

  assign cand = flag_q & ier_q & {NUM_LINES{gie_q}};

  always_comb begin
    win_vld = flag_q[0];
    win_idx = '0;
    if (!flag_q[0]) begin
      for (int i = NUM_LINES - 1; i >= FIRST_MASKABLE; i--) begin
        if (cand[i]) begin
          win_vld = 1'b1;
          win_idx = VEC_W'(i);
        end
      end
    end
  end

  assign irq_req = win_vld;
  assign irq_vec = win_idx;
  assign take    = irq_ack && win_vld;

  assign set_v = (src_evt | ((reg_we && reg_sel == 2'd1) ? reg_wdata : '0)) & LATCHABLE;
  assign clr_v = ((reg_we && reg_sel == 2'd0) ? reg_wdata : '0)
               | (take ? (NUM_LINES'(1) << win_idx) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      ier_q    <= '0;
      gie_q    <= 1'b0;
      sav_q    <= 1'b0;
      ret_addr <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      if (reg_we && reg_sel == 2'd2) ier_q <= reg_wdata & MASKABLE;
      if (take) begin
        sav_q    <= gie_q;
        gie_q    <= 1'b0;
        ret_addr <= pc_in;
      end else if (rti) begin
        gie_q <= sav_q;
      end else if (reg_we && reg_sel == 2'd3) begin
        gie_q <= reg_wdata[0];
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd2:    reg_rdata = ier_q;
      2'd3:    reg_rdata = {{(NUM_LINES-2){1'b0}}, sav_q, gie_q};
      default: reg_rdata = flag_q;
    endcase
  end

  p_reserved_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~LATCHABLE) == '0);

  p_evt_latches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt & LATCHABLE) != '0 |=> (flag_q & $past(src_evt & LATCHABLE)) == $past(src_evt & LATCHABLE));

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec != '0) |-> (gie_q && ier_q[irq_vec] && flag_q[irq_vec]));

  p_line0_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[0] |-> (irq_req && irq_vec == '0));

  p_ack_gie_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (!gie_q && ret_addr == $past(pc_in) && sav_q == $past(gie_q)));

  p_rti_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !(irq_ack && irq_req)) |=> gie_q == $past(sav_q));

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req) |=> $stable(ret_addr));

endmodule

// File: tb/sim_cpu_irq_ctrl.sv
module sim_cpu_irq_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_evt = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic        irq_ack = 1'b0;
  logic [31:0] pc_in = '0;
  logic        rti = 1'b0;
  logic [31:0] ret_addr;

  cpu_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .pc_in(pc_in), .rti(rti), .ret_addr(ret_addr)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  logic [15:0] m_flag = '0, m_ier = '0;
  bit          m_gie = 0, m_sav = 0;
  logic [31:0] m_ret = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, tag, act, exp);
    end
  endtask

  task automatic model_win(output bit v, output int w);
    v = 0; w = 0;
    for (int i = 15; i >= 4; i--)
      if (m_flag[i] && m_ier[i] && m_gie) begin v = 1; w = i; end
    if (m_flag[0]) begin v = 1; w = 0; end
  endtask

  task automatic cycle(input logic [15:0] evt, input bit we, input logic [1:0] sel,
                       input logic [15:0] wd, input bit ack, input logic [31:0] pc, input bit r);
    bit v; int w; bit tk;
    logic [15:0] setm, clrm;
    @(negedge clk);
    src_evt = evt; reg_we = we; reg_sel = sel; reg_wdata = wd;
    irq_ack = ack; pc_in = pc; rti = r;
    #1;
    model_win(v, w);
    check("irq_req", 32'(irq_req), 32'(v));
    if (v) check("irq_vec", 32'(irq_vec), 32'(w));
    check("ret_addr", ret_addr, m_ret);
    case (sel)
      2'd2:    check("rdata", 32'(reg_rdata), 32'(m_ier));
      2'd3:    check("rdata", 32'(reg_rdata), {30'd0, m_sav, m_gie});
      default: check("rdata", 32'(reg_rdata), 32'(m_flag));
    endcase
    @(posedge clk);
    tk   = v && ack;
    setm = (evt | ((we && sel == 2'd1) ? wd : 16'h0)) & 16'hFFF1;
    clrm = ((we && sel == 2'd0) ? wd : 16'h0) | (tk ? (16'h1 << w) : 16'h0);
    m_flag = (m_flag & ~clrm) | setm;
    if (we && sel == 2'd2) m_ier = wd & 16'hFFF0;
    if (tk) begin m_sav = m_gie; m_gie = 0; m_ret = pc; end
    else if (r) m_gie = m_sav;
    else if (we && sel == 2'd3) m_gie = wd[0];
  endtask

  task automatic idle(input logic [1:0] sel);
    cycle(16'h0, 0, sel, 16'h0, 0, 32'h0, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    cur_req = "watchdog";
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 2);
    #1;
    cur_req = "R11";
    check("irq_req", 32'(irq_req), 32'h0);
    check("ret_addr", ret_addr, 32'h0);
    check("rdata", 32'(reg_rdata), 32'h0);
    rst_n = 1'b1;
    idle(2'd2); idle(2'd3);

    cur_req = "R1";
    cycle(16'h022E, 0, 2'd0, 16'h0, 0, 32'h0, 0);
    idle(2'd0);

    cur_req = "R9";
    cycle(16'h0, 1, 2'd2, 16'hFFFF, 0, 32'h0, 0);
    idle(2'd2);
    cycle(16'h0, 1, 2'd1, 16'h900E, 0, 32'h0, 0);
    idle(2'd0);
    cycle(16'h0, 1, 2'd0, 16'h8000, 0, 32'h0, 0);
    idle(2'd0);

    cur_req = "R2";
    idle(2'd0);
    cycle(16'h0, 1, 2'd2, 16'hFDDF, 0, 32'h0, 0);
    cycle(16'h0, 1, 2'd3, 16'h0001, 0, 32'h0, 0);
    idle(2'd3);
    cycle(16'h0, 1, 2'd2, 16'hFFFF, 0, 32'h0, 0);

    cur_req = "R4";
    idle(2'd0); idle(2'd0);

    cur_req = "R5";
    cycle(16'h0, 0, 2'd0, 16'h0, 1, 32'h0000_1234, 0);
    idle(2'd0);

    cur_req = "R6";
    idle(2'd3);

    cur_req = "R7";
    cycle(16'h0, 1, 2'd3, 16'h0000, 0, 32'h0, 1);
    idle(2'd3);

    cur_req = "R8";
    cycle(16'h0200, 0, 2'd0, 16'h0, 1, 32'h0000_2000, 0);
    idle(2'd0);
    cycle(16'h0200, 1, 2'd0, 16'h0200, 0, 32'h0, 0);
    idle(2'd0);

    cur_req = "R3";
    cycle(16'h0, 1, 2'd3, 16'h0000, 0, 32'h0, 0);
    cycle(16'h0, 1, 2'd2, 16'h0000, 0, 32'h0, 0);
    cycle(16'h0001, 0, 2'd0, 16'h0, 0, 32'h0, 0);
    idle(2'd0);
    cycle(16'h0, 0, 2'd0, 16'h0, 1, 32'h0000_3000, 0);

    cur_req = "R10";
    cycle(16'h0, 1, 2'd0, 16'hFFFF, 0, 32'h0, 0);
    cycle(16'h0, 0, 2'd0, 16'h0, 1, 32'hDEAD_BEEF, 0);
    idle(2'd0); idle(2'd2); idle(2'd3);

    cur_req = "R4";
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] e;
      e = 16'($urandom) & 16'($urandom) & 16'($urandom);
      cycle(e, ($urandom % 4) == 0, 2'($urandom), 16'($urandom),
            ($urandom % 3) == 0, $urandom, ($urandom % 8) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule